// File: doc/BRIEF.md
# Bitmap Stream to RGB565 Frame Buffer Loader

The block reads an image file one byte at a time and stores it in a frame buffer through a write port with address, data and write enable. It decodes the leading file header and the 40-byte info header that follows it, and checks them against the panel size fixed at build time. It then turns each 24-bit pixel, which arrives blue first, into a 16-bit 5:6:5 word. The file holds its rows bottom-up, so the first row in the stream goes to the last buffer row and later rows move upward. Within a row, columns go left to right.

When the stream does not open with the bitmap signature, the block copies the bytes straight into the buffer as 16-bit words. If a header check fails, or the stream ends before the buffer is full, the block raises a one-cycle error pulse so that the surrounding system can show a test pattern instead. A `start` pulse arms the block for the next image. After the done or error pulse, the block ignores all bytes until the next `start`.

Top module: `bmp_fb_loader`

## Requirements
- R1: After reset, `fb_we`, `done` and `err` are low, and bytes are ignored until `start` is pulsed.
- R2: Bytes 0 and 1 of the stream form a little-endian 16-bit value.
  - If that value is not 0x4D42, the stream is copied raw.
  - In a raw copy, each byte pair becomes one word, with the earlier byte in bits 7:0. Words go to addresses 0, 1, 2 and so on.
  - `done` pulses after word W*H-1 is written.
- R3: If a raw copy sees `in_last` before W*H words are written, `err` pulses.
- R4: Header fields are little-endian at these byte offsets: file size 2..5, pixel offset 10..13, info size 14..17, width 18..21, height 22..25, bit count 28..29. A pixel offset greater than or equal to the file size causes `err`.
- R5: An info size other than 40, or a bit count other than 24, causes `err`.
- R6: A width other than W, or a height other than H, causes `err`.
- R7: A pixel offset below 54, which would overlap the headers, causes `err`.
- R8: Bytes from index 54 up to the pixel offset are skipped. Pixel data starts exactly at the pixel offset.
- R9: Each pixel is three bytes in the order blue, green, red. It is written as {red[7:3], green[7:2], blue[7:3]}. Rows carry no padding.
- R10: Pixel k of the stream (from 0) is written to address (H-1-k/W)*W + k%W.
- R11: Each image gives exactly one pulse, either `done` or `err`, never both. `done` follows the write of the final pixel. Bytes after that, including `in_last`, are ignored.
- R12: `in_last` before the final pixel, in either the header or the pixel data, causes `err`.
- R13: From the `err` pulse onward, `fb_we` stays low until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Arms the block for a new image |
| in_valid | input | 1 | A stream byte is present |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of the stream |
| fb_we | output | 1 | Frame buffer write enable |
| fb_addr | output | AW | Frame buffer word address, AW = clog2(W*H) |
| fb_data | output | 16 | Frame buffer word |
| done | output | 1 | One-cycle pulse: image complete |
| err | output | 1 | One-cycle pulse: header rejected or stream truncated |

## Verification
The hardest conditions to reach from the ports are the ones that need a header that is almost valid. Examples are a pixel offset below the header length while the offset is still below the file size, and a gap of filler bytes before the pixel data. The bench builds every header field by field with a bench function and corrupts one field per case, so each rejection path is reached in isolation. It also cuts streams at chosen byte counts, both inside the header and partway through a pixel, to reach the truncation error after some writes have already occurred. Random pixel bytes with random idle gaps cover the conversion and the bottom-up addressing.

// File: rtl/bmp_pkg.sv
package bmp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_BODY,
        ST_RAW,
        ST_FIN
    } ld_state_e;

    localparam logic [15:0] SIGNATURE  = 16'h4D42;
    localparam int          HDR_BYTES  = 54;
    localparam int          INFO_BYTES = 40;
    localparam int          PIX_BITS   = 24;
endpackage

// File: rtl/bmp_hdr_check.sv
module bmp_hdr_check #(
    parameter int W = 4,
    parameter int H = 3
) (
    input  logic [31:0] fsize,
    input  logic [31:0] pix_off,
    input  logic [31:0] info_size,
    input  logic [15:0] bit_count,
    input  logic [31:0] img_w,
    input  logic [31:0] img_h,
    output logic        hdr_ok
);
    import bmp_pkg::*;

    logic off_ok;
    logic fmt_ok;
    logic dim_ok;

    always_comb begin
        off_ok = (pix_off < fsize) && (pix_off >= 32'(HDR_BYTES));
        fmt_ok = (info_size == 32'(INFO_BYTES)) && (bit_count == 16'(PIX_BITS));
        dim_ok = (img_w == 32'(W)) && (img_h == 32'(H));
        hdr_ok = off_ok && fmt_ok && dim_ok;
    end
endmodule

// File: rtl/bmp_pix_pack.sv
module bmp_pix_pack (
    input  logic [7:0]  red,
    input  logic [7:0]  green,
    input  logic [7:0]  blue,
    output logic [15:0] word
);
    always_comb begin
        word = {red[7:3], green[7:2], blue[7:3]};
    end
endmodule

// File: rtl/bmp_fb_loader.sv
module bmp_fb_loader #(
    parameter int W = 4,
    parameter int H = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        in_valid,
    input  logic [7:0]                  in_data,
    input  logic                        in_last,
    output logic                        fb_we,
    output logic [$clog2(W*H)-1:0]      fb_addr,
    output logic [15:0]                 fb_data,
    output logic                        done,
    output logic                        err
);
    import bmp_pkg::*;

    localparam int N  = W * H;
    localparam int AW = $clog2(N);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        ld_state_e      st;
        logic [31:0]    pos;
        logic [31:0]    sh;
        logic [31:0]    fsize;
        logic [31:0]    off;
        logic [31:0]    isize;
        logic [31:0]    wid;
        logic [31:0]    hgt;
        logic [7:0]     lo;
        logic [7:0]     blue;
        logic [7:0]     green;
        logic [1:0]     phase;
        logic [CW-1:0]  col;
        logic [AW-1:0]  base;
        logic [AW-1:0]  waddr;
        logic           we;
        logic [AW-1:0]  addr;
        logic [15:0]    data;
        logic           done;
        logic           err;
    } ld_regs_t;

    ld_regs_t q, d;
    logic [31:0] sh_next;
    logic        hdr_ok;
    logic [15:0] pix_word;

    assign sh_next = {in_data, q.sh[31:8]};

    bmp_hdr_check #(.W(W), .H(H)) i_hdr_check (
        .fsize     (q.fsize),
        .pix_off   (q.off),
        .info_size (q.isize),
        .bit_count (sh_next[31:16]),
        .img_w     (q.wid),
        .img_h     (q.hgt),
        .hdr_ok    (hdr_ok)
    );

    bmp_pix_pack i_pix_pack (
        .red   (in_data),
        .green (q.green),
        .blue  (q.blue),
        .word  (pix_word)
    );

    always_comb begin
        d      = q;
        d.we   = 1'b0;
        d.done = 1'b0;
        d.err  = 1'b0;
        if (start) begin
            d.st    = ST_HDR;
            d.pos   = '0;
            d.phase = '0;
            d.col   = '0;
            d.base  = AW'((H - 1) * W);
            d.waddr = '0;
        end else if (in_valid) begin
            case (q.st)
                ST_HDR: begin
                    d.pos = q.pos + 32'd1;
                    d.sh  = sh_next;
                    case (q.pos)
                        32'd0:  d.lo = in_data;
                        32'd1: begin
                            if ({in_data, q.lo} != SIGNATURE) begin
                                d.st    = ST_RAW;
                                d.we    = 1'b1;
                                d.addr  = '0;
                                d.data  = {in_data, q.lo};
                                d.waddr = AW'(1);
                            end
                        end
                        32'd5:  d.fsize = sh_next;
                        32'd13: d.off   = sh_next;
                        32'd17: d.isize = sh_next;
                        32'd21: d.wid   = sh_next;
                        32'd25: d.hgt   = sh_next;
                        32'd29: begin
                            if (hdr_ok) begin
                                d.st = ST_BODY;
                            end else begin
                                d.st  = ST_FIN;
                                d.err = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
                ST_BODY: begin
                    d.pos = q.pos + 32'd1;
                    if (q.pos >= q.off) begin
                        case (q.phase)
                            2'd0: begin
                                d.blue  = in_data;
                                d.phase = 2'd1;
                            end
                            2'd1: begin
                                d.green = in_data;
                                d.phase = 2'd2;
                            end
                            default: begin
                                d.phase = 2'd0;
                                d.we    = 1'b1;
                                d.addr  = q.base + AW'(q.col);
                                d.data  = pix_word;
                                if (q.col == CW'(W - 1)) begin
                                    d.col = '0;
                                    if (q.base == '0) begin
                                        d.st   = ST_FIN;
                                        d.done = 1'b1;
                                    end else begin
                                        d.base = q.base - AW'(W);
                                    end
                                end else begin
                                    d.col = q.col + CW'(1);
                                end
                            end
                        endcase
                    end
                end
                ST_RAW: begin
                    d.pos = q.pos + 32'd1;
                    if (!q.pos[0]) begin
                        d.lo = in_data;
                    end else begin
                        d.we   = 1'b1;
                        d.addr = q.waddr;
                        d.data = {in_data, q.lo};
                        if (q.waddr == AW'(N - 1)) begin
                            d.st   = ST_FIN;
                            d.done = 1'b1;
                        end else begin
                            d.waddr = q.waddr + AW'(1);
                        end
                    end
                end
                default: ;
            endcase
            if (in_last && (q.st == ST_HDR || q.st == ST_BODY || q.st == ST_RAW)
                && !d.done && !d.err) begin
                d.st  = ST_FIN;
                d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign fb_we   = q.we;
    assign fb_addr = q.addr;
    assign fb_data = q.data;
    assign done    = q.done;
    assign err     = q.err;
endmodule

// File: rtl/bmp_fb_loader_chk.sv
module bmp_fb_loader_chk #(
    parameter int N  = 12,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          in_valid,
    input logic          fb_we,
    input logic [AW-1:0] fb_addr,
    input logic          done,
    input logic          err
);
    logic err_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_seen <= 1'b0;
        end else if (start) begin
            err_seen <= 1'b0;
        end else if (err) begin
            err_seen <= 1'b1;
        end
    end

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> (32'(fb_addr) < N)); // R10
    AST_WE_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> $past(in_valid)); // R2
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err); // R11
    AST_NO_WRITE_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        err_seen |-> !fb_we); // R13
endmodule

bind bmp_fb_loader bmp_fb_loader_chk #(.N(W * H), .AW($clog2(W * H))) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_valid (in_valid),
    .fb_we    (fb_we),
    .fb_addr  (fb_addr),
    .done     (done),
    .err      (err)
);

// File: tb/test_bmp_fb_loader.sv
`timescale 1ns/1ps
module test_bmp_fb_loader;
    localparam int W  = 4;
    localparam int H  = 3;
    localparam int N  = W * H;
    localparam int AW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_last = 1'b0;
    logic          fb_we;
    logic [AW-1:0] fb_addr;
    logic [15:0]   fb_data;
    logic          done;
    logic          err;

    int checks = 0;
    int errors = 0;

    logic [7:0]  bb [0:159];
    int          blen;
    logic [15:0] got [0:N-1];
    logic [15:0] expw [0:N-1];
    int          wcount, dcount, ecount, post_err_writes;
    logic        err_seen;

    always #5 clk = ~clk;

    bmp_fb_loader #(.W(W), .H(H)) i_bmp_fb_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .fb_we(fb_we), .fb_addr(fb_addr),
        .fb_data(fb_data), .done(done), .err(err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (fb_we) begin
                got[fb_addr] = fb_data;
                wcount++;
                if (err_seen) post_err_writes++;
            end
            if (done) dcount++;
            if (err) begin
                ecount++;
                err_seen = 1'b1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put32(input int idx, input int val);
        for (int i = 0; i < 4; i++) bb[idx + i] = 8'((val >> (8 * i)) & 255);
    endtask

    // Builds a bitmap with random pixel bytes; filler between header and offset
    task automatic build_bmp(input int fsize, input int off, input int isz,
                             input int bits, input int w, input int h);
        for (int i = 0; i < 160; i++) bb[i] = 8'hAA;
        bb[0] = 8'h42; bb[1] = 8'h4D;
        put32(2, fsize); put32(6, 0); put32(10, off); put32(14, isz);
        put32(18, w); put32(22, h);
        bb[26] = 8'd1; bb[27] = 8'd0;
        bb[28] = 8'(bits & 255); bb[29] = 8'(bits >> 8);
        put32(30, 0);
        for (int i = 0; i < 3 * N; i++)
            if (off + i < 160) bb[off + i] = 8'($urandom & 255);
        blen = off + 3 * N;
    endtask

    function automatic logic [15:0] pack(input logic [7:0] r, input logic [7:0] g,
                                         input logic [7:0] b);
        return {r[7:3], g[7:2], b[7:3]};
    endfunction

    task automatic expect_bmp(input int off);
        for (int k = 0; k < N; k++)
            expw[(H - 1 - k / W) * W + k % W] =
                pack(bb[off + 3 * k + 2], bb[off + 3 * k + 1], bb[off + 3 * k]);
    endtask

    task automatic send(input int len);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wcount = 0; dcount = 0; ecount = 0; post_err_writes = 0; err_seen = 1'b0;
        for (int i = 0; i < N; i++) got[i] = 16'hDEAD;
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_data  = bb[i];
            in_last  = (i == len - 1);
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
            if (($urandom & 3) == 0) @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic cmp_all(input string req);
        int bad = 0;
        for (int i = 0; i < N; i++) if (got[i] !== expw[i]) bad++;
        check(req, bad, 0);
    endtask

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        check("R1 we after reset", int'(fb_we), 0);
        check("R1 done/err after reset", int'(done | err), 0);
        rst_n = 1'b1;
        // bytes before start are ignored
        in_valid = 1'b1; in_data = 8'h11; in_last = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        @(negedge clk);
        check("R1 idle ignores bytes", int'(fb_we | done | err), 0);

        // R9 R10: valid images, random pixels
        for (int it = 0; it < 5; it++) begin
            build_bmp(54 + 3 * N, 54, 40, 24, W, H);
            expect_bmp(54);
            send(blen);
            cmp_all("R9 R10 pixel words and placement");
            check("R11 one done", dcount, 1);
            check("R11 no err", ecount, 0);
            check("R10 write count", wcount, N);
        end

        // R8: gap before pixel data, then trailing bytes after done (R11)
        build_bmp(200, 61, 40, 24, W, H);
        expect_bmp(61);
        send(blen + 5);
        cmp_all("R8 skip to offset");
        check("R11 trailing ignored writes", wcount, N);
        check("R11 trailing ignored err", ecount, 0);

        // R2: raw copy, first pair is a partial signature
        for (int i = 0; i < 160; i++) bb[i] = 8'($urandom & 255);
        bb[0] = 8'h42; bb[1] = 8'h00;
        for (int k = 0; k < N; k++) expw[k] = {bb[2 * k + 1], bb[2 * k]};
        send(2 * N + 3);
        cmp_all("R2 raw words");
        check("R2 raw done", dcount, 1);
        check("R2 raw writes", wcount, N);
        check("R2 raw no err", ecount, 0);

        // R3: raw stream too short
        bb[0] = 8'h00;
        send(2 * N - 4);
        check("R3 short raw err", ecount, 1);
        check("R3 short raw done", dcount, 0);
        check("R3 short raw writes", wcount, N - 2);

        // R4: offset equal to file size
        build_bmp(90, 90, 40, 24, W, H);
        blen = 100;
        send(blen);
        check("R4 offset>=size err", ecount, 1);
        check("R4 no writes", wcount, 0);
        // R4 field decode: offset one below size is accepted
        build_bmp(62, 61, 40, 24, W, H);
        expect_bmp(61);
        send(blen);
        check("R4 offset<size accepted", ecount, 0);
        cmp_all("R4 offset<size pixels");

        // R5: info size / bit count
        build_bmp(90, 54, 12, 24, W, H);
        send(blen);
        check("R5 info size err", ecount, 1);
        check("R13 no write after err", post_err_writes, 0);
        check("R13 no writes", wcount, 0);
        build_bmp(90, 54, 40, 16, W, H);
        send(blen);
        check("R5 bit count err", ecount, 1);
        check("R11 err without done", dcount, 0);

        // R6: dimensions
        build_bmp(90, 54, 40, 24, W + 1, H);
        send(blen);
        check("R6 width err", ecount, 1);
        build_bmp(90, 54, 40, 24, W, H - 1);
        send(blen);
        check("R6 height err", ecount, 1);

        // R7: offset inside the header
        build_bmp(90, 50, 40, 24, W, H);
        send(blen);
        check("R7 short offset err", ecount, 1);
        check("R7 no writes", wcount, 0);

        // R12: truncated pixel data, cut partway through a pixel
        build_bmp(90, 54, 40, 24, W, H);
        send(54 + 20);
        check("R12 truncated err", ecount, 1);
        check("R12 partial writes", wcount, 6);
        check("R13 nothing after err", post_err_writes, 0);
        // R12: truncated header
        send(20);
        check("R12 header cut err", ecount, 1);
        check("R12 header cut writes", wcount, 0);

        report();
    end
endmodule